// File: doc/BRIEF.md
# Low-Frequency Antenna Resonance Sweep Controller

This block finds the resonance of a low-frequency antenna by stepping a carrier divisor through a range and measuring the antenna voltage at each step. A one-cycle start pulse first zeroes a result memory with one entry per divisor value. The block then moves the divisor from its highest value toward its lowest, one step at a time. At each step it waits a fixed settle time. It then runs a burst of analog-to-digital conversions and reduces them to a rounded average, which it scales to a millivolt-proportional 8-bit figure. That figure is stored at the memory entry whose index is the divisor. When the last divisor has been handled, a done flag stays high until the next start.

The conversion source is a 10-bit converter outside the block, reached through a start pulse and a done strobe that carries the code. The carrier generator consumes `div_o`. Software or a neighbouring block reads the results through a synchronous read port with one cycle of latency. The settle delay is computed from the clock frequency and the settle time in milliseconds.

The controller is a single state machine with these states:
- `ST_IDLE` (waiting): goes to `ST_CLEAR` on a start pulse.
- `ST_CLEAR`: walks every memory entry, then goes to `ST_APPLY` and loads the first divisor.
- `ST_APPLY`: arms the settle timer and clears the accumulator, then goes to `ST_SETTLE`.
- `ST_SETTLE`: goes to `ST_REQ` when the timer expires.
- `ST_REQ`: issues the conversion pulse, then goes to `ST_WAIT`.
- `ST_WAIT`: on a done strobe, goes back to `ST_REQ`, or to `ST_STORE` after the last sample.
- `ST_STORE`: writes the result, then goes to `ST_APPLY` with the divisor lowered by one, or to `ST_IDLE` after the final divisor.

Top module: `lf_sweep_ctrl`

## Requirements
- R1: A start pulse while idle raises `busy_o` on the next cycle and sets all 256 result entries to zero before any divisor step; entries never reached by the sweep (indices 0 to 19) read zero afterwards, and an entry not yet revisited in the current sweep reads zero even if an earlier sweep wrote it.
- R2: The divisor applied on `div_o` starts at 255 and falls by exactly one per step; the last step uses 20, so 19 and lower are never applied during a sweep (236 steps in total).
- R3: After each new divisor appears on `div_o`, no conversion is requested for at least SETTLE_TICKS = (CLK_HZ/1000)*SETTLE_MS clock cycles.
- R4: Each step issues exactly 32 conversion requests; `adc_start_o` is a one-cycle pulse, and a new request is issued only after the done strobe for the previous one.
- R5: The step average is (S + 15) >> 5, where S is the sum of the 32 codes of that step.
- R6: The stored value is the low 8 bits of (137500 * average) >> 18. It is written to the entry whose index equals the divisor of that step, and it appears on `rd_data_o` one cycle after `rd_addr_i` is presented.
- R7: After the final store, `done_o` is high and `busy_o` is low; `done_o` stays high until the next accepted start and is low while a sweep runs.
- R8: A start pulse during a sweep has no effect: the divisor sequence, the request count and the stored results are those of an undisturbed sweep.
- R9: After reset, `busy_o`, `done_o` and `adc_start_o` are low and `div_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a sweep |
| busy_o | output | 1 | High while a sweep (including the clear) is in progress |
| done_o | output | 1 | High from the end of a sweep until the next accepted start |
| div_o | output | DIV_W (8) | Carrier divisor currently applied |
| adc_start_o | output | 1 | One-cycle conversion request |
| adc_done_i | input | 1 | Conversion complete strobe |
| adc_code_i | input | CODE_W (10) | Conversion result, valid with `adc_done_i` |
| rd_addr_i | input | DIV_W (8) | Result memory read index |
| rd_data_o | output | RES_W (8) | Result at `rd_addr_i`, one cycle later |

## Verification
A state machine that skips or repeats a step shows up on `div_o` at the first divisor change. It appears as a jump other than minus one, or as a sweep that does not end at 20. A sample counter that is off by one leaves the request count per step wrong by the next divisor change, and it also moves the stored average. A broken clear only appears through the read port: an entry written by one sweep still holds its old value while the next sweep is running, before that sweep reaches the entry again. An error in the rounding or scaling is visible only in the memory contents after the sweep, so every entry is read back and compared.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_APPLY,
        ST_SETTLE,
        ST_REQ,
        ST_WAIT,
        ST_STORE
    } lfs_state_e;

endpackage

// File: rtl/lfs_settle_timer.sv
// Down-counter that measures the settle window after each divisor change.
module lfs_settle_timer #(
    parameter int unsigned TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned TMR_W = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(TICKS - 1);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0) && !load_i;

endmodule

// File: rtl/lfs_avg_scale.sv
// Sums a burst of conversion codes, then rounds, averages and scales the sum.
module lfs_avg_scale #(
    parameter int unsigned CODE_W      = 10,
    parameter int unsigned AVG_LOG2    = 5,
    parameter int unsigned SCALE_MUL   = 137500,
    parameter int unsigned SCALE_SHIFT = 18,
    parameter int unsigned OUT_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              last_o,
    output logic [OUT_W-1:0]  result_o
);
    localparam int unsigned SUM_W   = CODE_W + AVG_LOG2;
    localparam int unsigned AVG_W   = CODE_W + 1;
    localparam int unsigned MUL_W   = $clog2(SCALE_MUL + 1);
    localparam int unsigned PROD_W  = AVG_W + MUL_W;
    localparam int unsigned N_SAMP  = 1 << AVG_LOG2;
    localparam int unsigned RND     = (N_SAMP / 2) - 1;
    localparam logic [AVG_LOG2-1:0] CNT_LAST = AVG_LOG2'(N_SAMP - 1);

    logic [SUM_W-1:0]    sum_q;
    logic [AVG_LOG2-1:0] cnt_q;
    logic [SUM_W:0]      rounded;
    logic [AVG_W-1:0]    avg;
    logic [PROD_W-1:0]   prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (clr_i) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (add_i) begin
            sum_q <= sum_q + SUM_W'(code_i);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rounded  = {1'b0, sum_q} + (SUM_W + 1)'(RND);
        avg      = AVG_W'(rounded >> AVG_LOG2);
        prod     = PROD_W'(avg) * PROD_W'(SCALE_MUL);
        result_o = OUT_W'(prod >> SCALE_SHIFT);
    end

    assign last_o = (cnt_q == CNT_LAST);

endmodule

// File: rtl/lfs_result_mem.sv
// Result storage indexed by divisor, one write port and one registered read port.
module lfs_result_mem #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/lf_sweep_ctrl.sv
module lf_sweep_ctrl
    import lfs_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 48_000_000,
    parameter int unsigned SETTLE_MS   = 20,
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned DIV_FIRST   = 255,
    parameter int unsigned DIV_LAST    = 20,
    parameter int unsigned CODE_W      = 10,
    parameter int unsigned AVG_LOG2    = 5,
    parameter int unsigned SCALE_MUL   = 137500,
    parameter int unsigned SCALE_SHIFT = 18,
    parameter int unsigned RES_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [DIV_W-1:0] div_o,
    output logic             adc_start_o,
    input  logic             adc_done_i,
    input  logic [CODE_W-1:0] adc_code_i,
    input  logic [DIV_W-1:0] rd_addr_i,
    output logic [RES_W-1:0] rd_data_o
);
    localparam int unsigned SETTLE_TICKS = (CLK_HZ / 1000) * SETTLE_MS;
    localparam int unsigned DEPTH        = 1 << DIV_W;
    localparam logic [DIV_W-1:0] FIRST_V = DIV_W'(DIV_FIRST);
    localparam logic [DIV_W-1:0] LAST_V  = DIV_W'(DIV_LAST);
    localparam logic [DIV_W-1:0] CLR_END = DIV_W'(DEPTH - 1);

    lfs_state_e state_q, state_d;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] clr_q;
    logic             done_q;

    logic             tmr_load, tmr_expired;
    logic             acc_clr, acc_add, acc_last;
    logic [RES_W-1:0] acc_result;
    logic             mem_we;
    logic [DIV_W-1:0] mem_waddr;
    logic [RES_W-1:0] mem_wdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                if (clr_q == CLR_END) state_d = ST_APPLY;
            end
            ST_APPLY: begin
                state_d = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_expired) state_d = ST_REQ;
            end
            ST_REQ: begin
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (adc_done_i) state_d = acc_last ? ST_STORE : ST_REQ;
            end
            ST_STORE: begin
                state_d = (div_q == LAST_V) ? ST_IDLE : ST_APPLY;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // sweep datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            clr_q  <= '0;
            done_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    clr_q <= '0;
                    if (start_i) done_q <= 1'b0;
                end
                ST_CLEAR: begin
                    clr_q <= clr_q + 1'b1;
                    if (clr_q == CLR_END) div_q <= FIRST_V;
                end
                ST_STORE: begin
                    if (div_q == LAST_V) begin
                        done_q <= 1'b1;
                    end else begin
                        div_q <= div_q - 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs and internal controls
    always_comb begin
        adc_start_o = (state_q == ST_REQ);
        tmr_load    = (state_q == ST_APPLY);
        acc_clr     = (state_q == ST_APPLY);
        acc_add     = (state_q == ST_WAIT) && adc_done_i;
        mem_we      = (state_q == ST_CLEAR) || (state_q == ST_STORE);
        mem_waddr   = (state_q == ST_CLEAR) ? clr_q : div_q;
        mem_wdata   = (state_q == ST_CLEAR) ? '0 : acc_result;
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        div_o       = div_q;
    end

    lfs_settle_timer #(
        .TICKS (SETTLE_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .expired_o (tmr_expired)
    );

    lfs_avg_scale #(
        .CODE_W      (CODE_W),
        .AVG_LOG2    (AVG_LOG2),
        .SCALE_MUL   (SCALE_MUL),
        .SCALE_SHIFT (SCALE_SHIFT),
        .OUT_W       (RES_W)
    ) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (acc_clr),
        .add_i    (acc_add),
        .code_i   (adc_code_i),
        .last_o   (acc_last),
        .result_o (acc_result)
    );

    lfs_result_mem #(
        .ADDR_W (DIV_W),
        .DATA_W (RES_W)
    ) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
    parameter int unsigned DIV_W        = 8,
    parameter int unsigned DIV_FIRST    = 255,
    parameter int unsigned DIV_LAST     = 20,
    parameter int unsigned SETTLE_TICKS = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div_o,
    input logic             adc_start_o,
    input logic             adc_done_i,
    input logic             busy_o,
    input logic             done_o
);
    localparam int unsigned SW = $clog2(SETTLE_TICKS + 2);
    localparam logic [SW-1:0]    CAP     = SW'(SETTLE_TICKS);
    localparam logic [DIV_W-1:0] FIRST_V = DIV_W'(DIV_FIRST);
    localparam logic [DIV_W-1:0] LAST_V  = DIV_W'(DIV_LAST);

    logic [DIV_W-1:0] div_prev_q;
    logic [SW-1:0]    since_q;
    logic [SW-1:0]    elapsed;
    logic             pend_q;

    assign elapsed = (div_o != div_prev_q) ? '0 : since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_prev_q <= '0;
            since_q    <= '0;
            pend_q     <= 1'b0;
        end else begin
            div_prev_q <= div_o;
            since_q    <= (elapsed >= CAP) ? CAP : elapsed + 1'b1;
            if (adc_start_o)     pend_q <= 1'b1;
            else if (adc_done_i) pend_q <= 1'b0;
        end
    end

    // R2: each divisor change is one step down, or the reload of the first value
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (div_o != $past(div_o)) |-> (div_o == $past(div_o) - 1'b1 || div_o == FIRST_V));

    // R2: no conversion below the last divisor
    a_r2_floor: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> (div_o >= LAST_V));

    // R3: settle window respected before every request
    a_r3_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> (elapsed >= CAP));

    // R4: request is a single-cycle pulse
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> !adc_start_o);

    // R4: no new request while one is outstanding
    a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |-> !pend_q);

    // R7: done flag only while idle
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

bind lf_sweep_ctrl lfs_checker #(
    .DIV_W        (DIV_W),
    .DIV_FIRST    (DIV_FIRST),
    .DIV_LAST     (DIV_LAST),
    .SETTLE_TICKS (SETTLE_TICKS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_o       (div_o),
    .adc_start_o (adc_start_o),
    .adc_done_i  (adc_done_i),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/sim_lf_sweep_ctrl.sv
module sim_lf_sweep_ctrl;
    localparam int CLK_HZ    = 2500;
    localparam int SETTLE_MS = 20;
    localparam int TICKS     = (CLK_HZ / 1000) * SETTLE_MS;
    localparam int N_STEPS   = 236;
    localparam int N_AVG     = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       adc_done_i = 1'b0;
    logic [9:0] adc_code_i = '0;
    logic [7:0] rd_addr_i = '0;
    logic       busy_o, done_o, adc_start_o;
    logic [7:0] div_o;
    logic [7:0] rd_data_o;

    always #10 clk = ~clk;

    lf_sweep_ctrl #(
        .CLK_HZ    (CLK_HZ),
        .SETTLE_MS (SETTLE_MS)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .div_o       (div_o),
        .adc_start_o (adc_start_o),
        .adc_done_i  (adc_done_i),
        .adc_code_i  (adc_code_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o)
    );

    int checks = 0;
    int errors = 0;
    int sums[256];
    int mode = 0;
    int k = 0, steps = 0, total_starts = 0, lat = 0, since = 0;
    int err_div = 0, err_cnt = 0, err_settle = 0, err_hs = 0;
    logic [7:0] last_div = '0;
    bit expect_first = 1'b0;
    bit start_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int code_for(input int m, input int d, input int kk);
        if (m == 0) return int'($urandom % 1024);
        if (m == 1) return 1023;
        return (kk < 31) ? 64 : 64 + (d % 32);
    endfunction

    function automatic int exp_store(input int s);
        longint avg;
        avg = longint'((s + 15) >> 5);
        return int'(((avg * 64'd137500) >> 18) & 64'd255);
    endfunction

    // behavioural converter plus protocol monitor
    initial begin
        forever begin
            @(negedge clk);
            adc_done_i = 1'b0;
            if (rst_n) begin
                since++;
                if (div_o != last_div) begin
                    if (expect_first) begin
                        if (div_o != 8'd255) err_div++;
                        expect_first = 1'b0;
                    end else begin
                        if (div_o != last_div - 8'd1) err_div++;
                        if (k != N_AVG) err_cnt++;
                    end
                    if (div_o < 8'd20) err_div++;
                    steps++;
                    k = 0;
                    since = 0;
                    last_div = div_o;
                end
                if (lat > 0) begin
                    lat--;
                    if (lat == 0) begin
                        adc_code_i = 10'(code_for(mode, int'(last_div), k));
                        sums[last_div] += int'(adc_code_i);
                        k++;
                        adc_done_i = 1'b1;
                    end
                end
                if (adc_start_o) begin
                    if (start_prev || lat != 0) err_hs++;
                    if (since < TICKS) err_settle++;
                    total_starts++;
                    lat = 1 + int'($urandom % 2);
                end
                start_prev = adc_start_o;
            end
        end
    end

    task automatic read_entry(input int a, output int v);
        @(negedge clk);
        rd_addr_i = 8'(a);
        @(negedge clk);
        v = int'(rd_data_o);
    endtask

    task automatic run_sweep(input int m);
        int cyc;
        int v;
        mode = m;
        for (int i = 0; i < 256; i++) sums[i] = 0;
        total_starts = 0;
        steps = 0;
        err_div = 0; err_cnt = 0; err_settle = 0; err_hs = 0;
        expect_first = 1'b1;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R1 busy after start", int'(busy_o), 1);
        chk(done_o == 1'b0, "R7 done cleared on start", int'(done_o), 0);
        if (m == 2) begin
            // earlier sweep left 24 at entry 20; the clear must have zeroed it
            cyc = 0;
            while (div_o != 8'd250 && cyc < 60000) begin @(negedge clk); cyc++; end
            read_entry(20, v);
            chk(v == 0, "R1 stale entry cleared", v, 0);
        end
        if (m == 0) begin
            cyc = 0;
            while (div_o != 8'd200 && cyc < 60000) begin @(negedge clk); cyc++; end
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk);
            chk(busy_o == 1'b1, "R8 busy kept", int'(busy_o), 1);
            chk(div_o == 8'd200, "R8 divisor kept", int'(div_o), 200);
        end
        cyc = 0;
        while (!done_o && cyc < 60000) begin @(negedge clk); cyc++; end
        chk(done_o == 1'b1, "R7 done set", int'(done_o), 1);
        chk(busy_o == 1'b0, "R7 idle at end", int'(busy_o), 0);
        chk(steps == N_STEPS, "R2 step count", steps, N_STEPS);
        chk(last_div == 8'd20, "R2 last divisor", int'(last_div), 20);
        chk(err_div == 0, "R2 divisor order", err_div, 0);
        chk(err_settle == 0, "R3 settle violations", err_settle, 0);
        chk(err_hs == 0, "R4 handshake violations", err_hs, 0);
        chk(err_cnt == 0 && k == N_AVG, "R4 samples per step", k, N_AVG);
        chk(total_starts == N_STEPS * N_AVG, "R4 R8 total requests", total_starts, N_STEPS * N_AVG);
        for (int a = 0; a < 256; a++) begin
            read_entry(a, v);
            if (a < 20) chk(v == 0, "R1 unswept entry", v, 0);
            else if (m == 2) chk(v == exp_store(sums[a]), "R5 rounded average", v, exp_store(sums[a]));
            else chk(v == exp_store(sums[a]), "R6 stored value", v, exp_store(sums[a]));
        end
        repeat (5) @(negedge clk);
        chk(done_o == 1'b1, "R7 done held", int'(done_o), 1);
    endtask

    initial begin
        void'($urandom(32'h5EED0A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R9 busy reset", int'(busy_o), 0);
        chk(done_o == 1'b0, "R9 done reset", int'(done_o), 0);
        chk(adc_start_o == 1'b0, "R9 request reset", int'(adc_start_o), 0);
        chk(div_o == 8'd0, "R9 divisor reset", int'(div_o), 0);
        run_sweep(1);   // full-scale codes: scaled 536 wraps to 24
        run_sweep(2);   // rounding threshold at remainder 16/17
        run_sweep(0);   // seeded random codes with a stray start pulse
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule